// File: doc/BRIEF.md
# EEPROM page-write and read sequencer

This block is the command engine of a small serial EEPROM. A bus front end decodes the two-wire line states and hands the sequencer start and stop events, each received byte, and each request for the next byte to send. The sequencer decides whether each byte is acknowledged and keeps a 9-bit address pointer. It stages page writes in a 16-entry buffer and runs a self-timed programming cycle into a 512 x 8 array. It also serves current-address, random and sequential reads.

The first byte after a start is the slave byte. Its upper nibble must be `1010`. Bits 3:2 must equal the strap input `dev_sel_i`. Bit 1 selects the half of the array and bit 0 selects read (1) or write (0). In write mode the next byte is the byte address and the bytes after it are data. When stop arrives after at least one data byte has been accepted, the block is busy for a fixed number of clocks and commits the staged bytes to the array. A write-protect input refuses data aimed at the upper half of the array.

Top module: `eep_seq`

## Requirements
- R1: A slave byte is acknowledged only if bits 7:4 equal 1010 and bits 3:2 equal `dev_sel_i`. On a mismatch the slave byte and every later byte up to the next start receive NACK.
- R2: In write mode, the byte after the slave byte is acknowledged and loads the address pointer with {slave bit 1, byte}.
- R3: Each data byte is acknowledged and staged at the pointer. After each byte only pointer bits 3:0 advance, so a 17th byte overwrites the first byte of the same 16-byte page.
- R4: A stop that follows at least one accepted data byte raises `busy_o` in the next cycle. `busy_o` then stays high for exactly WR_CYCLES cycles, and the array holds the staged data afterwards.
- R5: While `busy_o` is high, every received byte gets NACK and start, stop and read requests are ignored. A start in the final busy cycle is also ignored.
- R6: A stop after a write command that carried only a byte address leaves `busy_o` low.
- R7: When `wp_i` is high and the pointer's bit 8 is 1, data bytes get NACK and are not stored, and the following stop starts no cycle. Lower-half writes still proceed.
- R8: A read-mode slave byte starts reading at the current pointer and ignores its own bit 1. After a write, the pointer is the last written address plus one within the page.
- R9: A write command carrying only a byte address, followed by a repeated start and a read-mode slave byte, reads from the newly loaded address.
- R10: Every byte read advances all 9 pointer bits, so reading wraps from 511 to 0.
- R11: A `tx_req_i` pulse in read mode gives a one-cycle `tx_valid_o` pulse in the next cycle, with `tx_byte_o` holding the array byte.
- R12: Only staged bytes are committed. Other bytes of the page keep their contents.
- R13: After reset `busy_o`, `ack_valid_o` and `tx_valid_o` are low, the pointer is 0 and the array is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_sel_i | input | 2 | Strap value compared with slave byte bits 3:2 |
| wp_i | input | 1 | Write-protect for the upper half |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| rx_valid_i | input | 1 | A byte from the master is present |
| rx_byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Acknowledge decision valid, one cycle after rx_valid_i |
| ack_o | output | 1 | 1 = acknowledge, 0 = NACK |
| tx_req_i | input | 1 | Front end asks for the next read byte |
| tx_valid_o | output | 1 | Read byte valid |
| tx_byte_o | output | 8 | Read byte |
| busy_o | output | 1 | Self-timed programming cycle running |

## Verification
The end of the self-timed cycle can coincide with a new start on the bus. The bench tracks the expected busy window with its own counter and drives start exactly in the last cycle of that window. It then expects the following slave byte to be refused, and a fresh start to be accepted. The busy level is compared with the model on every clock, so an early, late or missing cycle is reported in the cycle it happens. Stops that should start no cycle, from an address-only write or a protected write, are judged the same way.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLAVE,
    ST_WADDR,
    ST_WDATA,
    ST_READ,
    ST_SKIP,
    ST_PROG
  } seq_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_page_i,
  input  logic              step_all_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
    end else if (step_all_i) begin
      addr_q <= addr_q + 1'b1;
    end else if (step_page_i) begin
      addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
    end
  end

  assign addr_o = addr_q;

  assert_page_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_page_i && !load_i && !step_all_i |=> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));

  assert_full_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_all_i && !load_i && (addr_o == {ADDR_W{1'b1}}) |=> addr_o == '0);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              any_o
);
  localparam int ENTRIES = 1 << PAGE_W;

  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[e] <= '0;
        vld_q[e]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[e]  <= 1'b0;
      end else if (wr_i && (wr_idx_i == PAGE_W'(e))) begin
        data_q[e] <= wr_data_i;
        vld_q[e]  <= 1'b1;
      end
    end
  end

  assign rd_data_o  = data_q[rd_idx_i];
  assign rd_valid_o = vld_q[rd_idx_i];
  assign any_o      = |vld_q;

  assert_buf_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> vld_q == '0);

  assert_buf_mark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i |=> vld_q[$past(wr_idx_i)]);
endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      if (re_i) rdata_q <= mem_q[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

  // reads come from the bus path, writes only from the program cycle
  assert_no_rw_clash_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] dev_sel_i,
  input  logic       wp_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  output logic       ack_valid_o,
  output logic       ack_o,
  input  logic       tx_req_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_byte_o,
  output logic       busy_o
);
  localparam int ADDR_W     = WORD_W + 1;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  seq_state_e        state_q, state_d;
  logic              pg_q, pg_d;
  logic              prot_q, prot_d;
  logic              ack_q, ack_d;
  logic              ack_valid_q, tx_valid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W:0]   commit_q;

  logic [ADDR_W-1:0] addr_w;
  logic              addr_load, step_page, step_all;
  logic              buf_clr, buf_wr, buf_any, buf_rd_vld;
  logic [7:0]        buf_rd_data;
  logic              mem_re, mem_we;
  logic              busy;
  logic              slave_hit;

  assign busy      = (state_q == ST_PROG);
  assign slave_hit = (rx_byte_i[7:4] == DEV_TYPE) && (rx_byte_i[3:2] == dev_sel_i);

  always_comb begin
    state_d   = state_q;
    pg_d      = pg_q;
    prot_d    = prot_q;
    ack_d     = 1'b0;
    addr_load = 1'b0;
    step_page = 1'b0;
    step_all  = 1'b0;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    mem_re    = 1'b0;
    if (busy) begin
      if (cnt_q == '0) state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = ST_SLAVE;
    end else if (stop_i) begin
      state_d = (state_q == ST_WDATA && buf_any) ? ST_PROG : ST_IDLE;
    end else if (rx_valid_i) begin
      unique case (state_q)
        ST_SLAVE: begin
          if (slave_hit) begin
            ack_d = 1'b1;
            if (rx_byte_i[0]) begin
              state_d = ST_READ;
            end else begin
              state_d = ST_WADDR;
              pg_d    = rx_byte_i[1];
            end
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_WADDR: begin
          ack_d     = 1'b1;
          addr_load = 1'b1;
          buf_clr   = 1'b1;
          prot_d    = 1'b0;
          state_d   = ST_WDATA;
        end
        ST_WDATA: begin
          if (prot_q || (wp_i && addr_w[ADDR_W-1])) begin
            prot_d = 1'b1;
          end else begin
            ack_d     = 1'b1;
            buf_wr    = 1'b1;
            step_page = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (tx_req_i && state_q == ST_READ) begin
      mem_re   = 1'b1;
      step_all = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pg_q        <= 1'b0;
      prot_q      <= 1'b0;
      ack_q       <= 1'b0;
      ack_valid_q <= 1'b0;
      tx_valid_q  <= 1'b0;
      cnt_q       <= '0;
      commit_q    <= '0;
    end else begin
      state_q     <= state_d;
      pg_q        <= pg_d;
      prot_q      <= prot_d;
      ack_q       <= ack_d;
      ack_valid_q <= rx_valid_i;
      tx_valid_q  <= mem_re;
      if (!busy && state_d == ST_PROG) begin
        cnt_q    <= CNT_W'(WR_CYCLES - 1);
        commit_q <= '0;
      end else if (busy) begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (!commit_q[PAGE_W]) commit_q <= commit_q + 1'b1;
      end
    end
  end

  // one staged entry per cycle during the program window
  assign mem_we = busy && !commit_q[PAGE_W] && buf_rd_vld;

  eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (addr_load),
    .load_val_i  ({pg_q, rx_byte_i}),
    .step_page_i (step_page),
    .step_all_i  (step_all),
    .addr_o      (addr_w)
  );

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (buf_clr),
    .wr_i       (buf_wr),
    .wr_idx_i   (addr_w[PAGE_W-1:0]),
    .wr_data_i  (rx_byte_i),
    .rd_idx_i   (commit_q[PAGE_W-1:0]),
    .rd_data_o  (buf_rd_data),
    .rd_valid_o (buf_rd_vld),
    .any_o      (buf_any)
  );

  eep_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i ({addr_w[ADDR_W-1:PAGE_W], commit_q[PAGE_W-1:0]}),
    .wdata_i (buf_rd_data),
    .re_i    (mem_re),
    .raddr_i (addr_w),
    .rdata_o (tx_byte_o)
  );

  assign ack_valid_o = ack_valid_q;
  assign ack_o       = ack_q;
  assign tx_valid_o  = tx_valid_q;
  assign busy_o      = busy;

  assert_busy_nack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rx_valid_i |=> ack_valid_o && !ack_o);

  assert_wp_refuse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !start_i && !stop_i && state_q == ST_WDATA && wp_i && addr_w[ADDR_W-1]
    |=> !ack_o);

  assert_addr_only_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i && !busy_o && state_q == ST_WDATA && !buf_any |=> !busy_o);

  assert_no_tx_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !tx_valid_o);

  assert_commit_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> commit_q[PAGE_W]);
endmodule

// File: tb/eep_seq_tb.sv
`timescale 1ns/1ps
module eep_seq_tb_top;
  localparam int WR = 24;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] dev_sel = SEL;
  logic wp = 1'b0, start = 1'b0, stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = '0;
  logic ack_valid, ack, tx_valid, busy;
  logic [7:0] tx_byte;

  always #5 clk = ~clk;

  eep_seq #(.WR_CYCLES(WR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dev_sel_i(dev_sel), .wp_i(wp),
    .start_i(start), .stop_i(stop), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .ack_valid_o(ack_valid), .ack_o(ack), .tx_req_i(tx_req),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem_m [512];
  int addr_m = 0;
  logic arm_prog = 1'b0;
  int mbusy = 0;
  logic [7:0] wq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference busy window
  always @(posedge clk) begin
    if (!rst_n) mbusy <= 0;
    else if (stop && arm_prog) mbusy <= WR;
    else if (mbusy > 0) mbusy <= mbusy - 1;
  end

  always @(negedge clk) if (rst_n) chk(busy == (mbusy > 0), "R4 busy window", int'(busy), int'(mbusy > 0));

  function automatic logic [7:0] slv(input int pg, input int rw);
    return {4'b1010, SEL, pg[0], rw[0]};
  endfunction

  task automatic drive_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic drive_stop(input bit prog);
    @(negedge clk); stop = 1'b1; arm_prog = prog;
    @(negedge clk); stop = 1'b0; arm_prog = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    chk(ack_valid === 1'b1 && ack === exp_ack, req, int'({ack_valid, ack}), int'({1'b1, exp_ack}));
  endtask

  task automatic fetch(input string req);
    logic [7:0] e;
    e = mem_m[addr_m];
    addr_m = (addr_m + 1) % 512;
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk(tx_valid === 1'b1 && tx_byte === e, req, int'(tx_byte), int'(e));
    @(negedge clk);
    chk(tx_valid === 1'b0, "R11 one-cycle pulse", int'(tx_valid), 0);
  endtask

  task automatic wait_idle;
    int guard = 0;
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  task automatic wr_txn(input int pg, input int wa, input bit refuse, input bit wait_done);
    logic [7:0] stage [int];
    int acc = 0;
    drive_start;
    send(slv(pg, 0), 1'b1, "R1");
    send(wa[7:0], 1'b1, "R2");
    addr_m = pg * 256 + wa;
    foreach (wq[i]) begin
      if (refuse) send(wq[i], 1'b0, "R7");
      else begin
        send(wq[i], 1'b1, "R3");
        stage[addr_m] = wq[i];
        addr_m = (addr_m & ~15) | ((addr_m + 1) & 15);
        acc++;
      end
    end
    drive_stop(acc > 0);
    foreach (stage[k]) mem_m[k] = stage[k];
    if (wait_done) wait_idle;
  endtask

  task automatic rd_cur(input int n, input int pg, input string req);
    drive_start;
    send(slv(pg, 1), 1'b1, req);
    for (int i = 0; i < n; i++) fetch(req);
    drive_stop(1'b0);
  endtask

  task automatic rd_rand(input int pg, input int wa, input int n, input string req);
    drive_start;
    send(slv(pg, 0), 1'b1, "R9");
    send(wa[7:0], 1'b1, "R9");
    addr_m = pg * 256 + wa;
    drive_start;
    send(slv(pg, 1), 1'b1, "R9");
    for (int i = 0; i < n; i++) fetch(req);
    drive_stop(1'b0);
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && ack_valid === 1'b0 && tx_valid === 1'b0, "R13 reset outputs",
        int'({busy, ack_valid, tx_valid}), 0);

    // byte write then random read of neighbours
    wq = {}; wq.push_back(8'h3C);
    wr_txn(0, 8'h05, 1'b0, 1'b1);
    rd_rand(0, 8'h04, 3, "R12");

    // 20-byte page write wraps in page
    wq = {};
    for (int i = 0; i < 20; i++) wq.push_back(8'(i * 7 + 1));
    wr_txn(1, 8'h2A, 1'b0, 1'b1);
    rd_cur(3, 1, "R8");

    // activity during the program cycle and start in its last cycle
    wq = {}; wq.push_back(8'h11); wq.push_back(8'h22);
    wr_txn(0, 8'h80, 1'b0, 1'b0);
    drive_start;
    send(slv(0, 0), 1'b0, "R5");
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk(tx_valid === 1'b0, "R5 read ignored", int'(tx_valid), 0);
    drive_stop(1'b0);
    while (mbusy != 1) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    send(slv(0, 0), 1'b0, "R5");
    rd_rand(0, 8'h7F, 4, "R12");

    // address-only write, then current read with other half bit
    drive_start;
    send(slv(1, 0), 1'b1, "R6");
    send(8'h30, 1'b1, "R6");
    addr_m = 9'h130;
    drive_stop(1'b0);
    chk(busy === 1'b0, "R6", int'(busy), 0);
    rd_cur(2, 0, "R8");

    // slave mismatch
    drive_start;
    send(8'hB4, 1'b0, "R1");
    send(8'h00, 1'b0, "R1");
    drive_stop(1'b0);
    drive_start;
    send({4'b1010, 2'b01, 2'b00}, 1'b0, "R1");
    drive_stop(1'b0);

    // write protect
    wp = 1'b1;
    wq = {}; wq.push_back(8'hAA); wq.push_back(8'hBB);
    wr_txn(1, 8'h40, 1'b1, 1'b1);
    rd_rand(1, 8'h40, 2, "R7");
    wq = {}; wq.push_back(8'h55);
    wr_txn(0, 8'h40, 1'b0, 1'b1);
    rd_rand(0, 8'h40, 1, "R7");
    wp = 1'b0;

    // sequential read across the top of the array
    wq = {}; wq.push_back(8'h9A); wq.push_back(8'h9B);
    wr_txn(1, 8'hFE, 1'b0, 1'b1);
    wq = {}; wq.push_back(8'h71);
    wr_txn(0, 8'h00, 1'b0, 1'b1);
    rd_rand(1, 8'hFE, 4, "R10");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule